// File: doc/BRIEF.md
# Debounced Fault Status Aggregator

This block sits between a set of raw analog comparator outputs on the primary side of a card supply and the logic that reports and acts on them. It takes eight single-bit comparator results: overvoltage, undervoltage, brownout, overcurrent, seat good, inrush done, and high-side and low-side fuse open. Each result passes through a two-flop synchronizer and then through its own time-qualified filter. A filter changes its output only after the synchronized input has disagreed with it for a set number of consecutive timebase ticks.

The filters count on a slow timebase, supplied as a single-cycle `tick` enable in the fast clock domain. Each channel has separate durations for entering and leaving the fault state. This lets the undervoltage path react within about 200 µs while still asking for 200 ms of good input before it clears. The filtered flags are brought out one by one for the shutdown and enable logic elsewhere. They are also packed into a registered eight-bit status word that carries a derived any-fault bit for the isolated reporting path. Brownout and overcurrent are warnings only: they set their own bits and the any-fault bit, and nothing else.

Top module: `fault_status_agg`

## Requirements
- R1: The status word uses one for fault and zero for normal, with bit 0 overvoltage, bit 1 undervoltage, bit 2 seat invalid, bit 3 inrush not complete, bit 4 fuse fail, bit 5 brownout, bit 6 overcurrent and bit 7 any fault. The word is registered one clock after the filtered flags.
- R2: While reset is held, and right after it, every filtered flag reads fault except brownout and overcurrent, which read cleared. The status word therefore reads 0x9F.
- R3: The any-fault bit is one exactly when at least one of status bits 0 to 6 is one.
- R4: The fuse-fail bit is one when either the high-side or the low-side fuse-open flag is one.
- R5: A raw input change enters a two-stage synchronizer. The filtered flag then takes the new value on the clock edge of the Nth consecutive tick in which the synchronized input differs from the flag. N is the channel's set duration when moving to fault and its clear duration when moving to normal. By default the overvoltage, overcurrent and both fuse filters use 25000 ticks each way, which is 200 ms at a 125 kHz tick.
- R6: If the synchronized input returns to the filtered value before the count completes, the count restarts from zero. A pulse shorter than N ticks, or a train of such pulses with gaps, leaves the flag unchanged.
- R7: The undervoltage, brownout and seat channels have different set and clear durations. Undervoltage defaults to 25 ticks to set and 25000 to clear, brownout to 25 and 25000, and seat invalid to 1250 and 6250.
- R8: Filter counts advance only in cycles where `tick` is high, so a filtered flag changes only on a tick cycle.
- R9: The seat-good and inrush-done inputs are active high. Each is inverted so that its status bit is one when seat is invalid or inrush is not complete.
- R10: Brownout and overcurrent change only their own flags, their own status bits and the any-fault bit. All other flags and bits stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase enable that advances the filters |
| ov_raw | input | 1 | Raw overvoltage comparator, high means fault |
| uv_raw | input | 1 | Raw undervoltage comparator, high means fault |
| brownout_raw | input | 1 | Raw brownout comparator, high means warning |
| oc_raw | input | 1 | Raw overcurrent comparator, high means warning |
| seat_ok_raw | input | 1 | Raw seat detect, high means seated |
| inrush_done_raw | input | 1 | Raw inrush-complete comparator, high means done |
| fuse_hi_open_raw | input | 1 | Raw high-side fuse check, high means open |
| fuse_lo_open_raw | input | 1 | Raw low-side fuse check, high means open |
| status_o | output | 8 | Registered status word, bit map in R1 |
| ov_o | output | 1 | Filtered overvoltage flag |
| uv_o | output | 1 | Filtered undervoltage flag |
| brownout_o | output | 1 | Filtered brownout flag |
| oc_o | output | 1 | Filtered overcurrent flag |
| seat_bad_o | output | 1 | Filtered seat-invalid flag |
| inrush_pend_o | output | 1 | Filtered inrush-not-complete flag |
| fuse_hi_open_o | output | 1 | Filtered high-side fuse-open flag |
| fuse_lo_open_o | output | 1 | Filtered low-side fuse-open flag |

## Verification
The bench samples one cycle before and one cycle after the expected flip of an overvoltage and an undervoltage transition. A filter that is off by one tick, skips the synchronizer, or uses the set time where the clear time belongs changes at the wrong edge. Pulse trains one tick shorter than the limit, with single-cycle gaps, target the restart rule: a counter that kept counting across gaps would let the fuse flag trip. With `tick` held low for many cycles, a filter that ignored the enable would still change state. A mid-run reset and the warnings-only case catch wrong reset polarities, swapped status bit positions, and brownout or overcurrent leaking into other channels.

// File: rtl/fault_status_pkg.sv
package fault_status_pkg;

  localparam int NUM_CH = 8;

  // filter channel order inside the block
  localparam int CH_OV   = 0;
  localparam int CH_UV   = 1;
  localparam int CH_BO   = 2;
  localparam int CH_OC   = 3;
  localparam int CH_SEAT = 4;
  localparam int CH_INR  = 5;
  localparam int CH_FH   = 6;
  localparam int CH_FL   = 7;

  // status word bit positions (decoded by downstream reporting logic)
  localparam int ST_OV   = 0;
  localparam int ST_UV   = 1;
  localparam int ST_SEAT = 2;
  localparam int ST_INR  = 3;
  localparam int ST_FUSE = 4;
  localparam int ST_BO   = 5;
  localparam int ST_OC   = 6;
  localparam int ST_ANY  = 7;
  localparam int ST_W    = 8;

  // reset value of the filtered flags: fault everywhere except warnings
  localparam logic [NUM_CH-1:0] CH_RST_VAL = 8'b1111_0011;
  localparam logic [ST_W-1:0]   ST_RST_VAL = 8'h9F;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
  parameter int              W       = 8,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/fault_filter.sv
module fault_filter #(
  parameter int   SET_TICKS = 25000,
  parameter int   CLR_TICKS = 25000,
  parameter logic RST_VAL   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic flag_o
);

  localparam int MAX_TICKS = (SET_TICKS > CLR_TICKS) ? SET_TICKS : CLR_TICKS;
  localparam int CW        = $clog2(MAX_TICKS + 1);
  localparam logic [CW-1:0] SET_LAST = CW'(SET_TICKS - 1);
  localparam logic [CW-1:0] CLR_LAST = CW'(CLR_TICKS - 1);

  logic          flag_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  // moving away from fault uses the clear time, towards fault the set time
  assign last = flag_q ? CLR_LAST : SET_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= RST_VAL;
      cnt_q  <= '0;
    end else if (din == flag_q) begin
      cnt_q  <= '0;
    end else if (tick) begin
      if (cnt_q == last) begin
        flag_q <= din;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/fault_status_pack.sv
module fault_status_pack
  import fault_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] flags,
  output logic [ST_W-1:0]   status_o
);

  logic [ST_W-1:0] st_d;
  logic [ST_W-1:0] st_q;

  always_comb begin
    st_d          = '0;
    st_d[ST_OV]   = flags[CH_OV];
    st_d[ST_UV]   = flags[CH_UV];
    st_d[ST_SEAT] = flags[CH_SEAT];
    st_d[ST_INR]  = flags[CH_INR];
    st_d[ST_FUSE] = flags[CH_FH] | flags[CH_FL];
    st_d[ST_BO]   = flags[CH_BO];
    st_d[ST_OC]   = flags[CH_OC];
    st_d[ST_ANY]  = |st_d[ST_ANY-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_RST_VAL;
    else     st_q <= st_d;
  end

  assign status_o = st_q;

endmodule

// File: rtl/fault_status_agg.sv
module fault_status_agg
  import fault_status_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int OV_TICKS       = 25000,
  parameter int UV_SET_TICKS   = 25,
  parameter int UV_CLR_TICKS   = 25000,
  parameter int BO_SET_TICKS   = 25,
  parameter int BO_CLR_TICKS   = 25000,
  parameter int OC_TICKS       = 25000,
  parameter int SEAT_SET_TICKS = 1250,
  parameter int SEAT_CLR_TICKS = 6250,
  parameter int INR_TICKS      = 100000,
  parameter int FUSE_TICKS     = 25000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       ov_raw,
  input  logic       uv_raw,
  input  logic       brownout_raw,
  input  logic       oc_raw,
  input  logic       seat_ok_raw,
  input  logic       inrush_done_raw,
  input  logic       fuse_hi_open_raw,
  input  logic       fuse_lo_open_raw,
  output logic [7:0] status_o,
  output logic       ov_o,
  output logic       uv_o,
  output logic       brownout_o,
  output logic       oc_o,
  output logic       seat_bad_o,
  output logic       inrush_pend_o,
  output logic       fuse_hi_open_o,
  output logic       fuse_lo_open_o
);

  localparam int SET_T [NUM_CH] = '{OV_TICKS, UV_SET_TICKS, BO_SET_TICKS, OC_TICKS,
                                    SEAT_SET_TICKS, INR_TICKS, FUSE_TICKS, FUSE_TICKS};
  localparam int CLR_T [NUM_CH] = '{OV_TICKS, UV_CLR_TICKS, BO_CLR_TICKS, OC_TICKS,
                                    SEAT_CLR_TICKS, INR_TICKS, FUSE_TICKS, FUSE_TICKS};

  logic [NUM_CH-1:0] raw_flt;
  logic [NUM_CH-1:0] sync_q;
  logic [NUM_CH-1:0] flt_q;

  // bring every input into fault-high polarity
  always_comb begin
    raw_flt          = '0;
    raw_flt[CH_OV]   = ov_raw;
    raw_flt[CH_UV]   = uv_raw;
    raw_flt[CH_BO]   = brownout_raw;
    raw_flt[CH_OC]   = oc_raw;
    raw_flt[CH_SEAT] = ~seat_ok_raw;
    raw_flt[CH_INR]  = ~inrush_done_raw;
    raw_flt[CH_FH]   = fuse_hi_open_raw;
    raw_flt[CH_FL]   = fuse_lo_open_raw;
  end

  fault_sync #(
    .W       (NUM_CH),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (CH_RST_VAL)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_flt),
    .q   (sync_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    fault_filter #(
      .SET_TICKS (SET_T[c]),
      .CLR_TICKS (CLR_T[c]),
      .RST_VAL   (CH_RST_VAL[c])
    ) u_filt (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .din    (sync_q[c]),
      .flag_o (flt_q[c])
    );
  end

  fault_status_pack u_pack (
    .clk      (clk),
    .rst      (rst),
    .flags    (flt_q),
    .status_o (status_o)
  );

  assign ov_o           = flt_q[CH_OV];
  assign uv_o           = flt_q[CH_UV];
  assign brownout_o     = flt_q[CH_BO];
  assign oc_o           = flt_q[CH_OC];
  assign seat_bad_o     = flt_q[CH_SEAT];
  assign inrush_pend_o  = flt_q[CH_INR];
  assign fuse_hi_open_o = flt_q[CH_FH];
  assign fuse_lo_open_o = flt_q[CH_FL];

endmodule

// File: rtl/fault_status_agg_chk.sv
module fault_status_agg_chk
  import fault_status_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [NUM_CH-1:0] flags,
  input logic [NUM_CH-1:0] synced,
  input logic [ST_W-1:0]   status
);

  logic past_rst = 1'b0;
  always_ff @(posedge clk) past_rst <= rst;

  assert_reset_value_R2: assert property (@(posedge clk)
    past_rst |-> (status == ST_RST_VAL && flags == CH_RST_VAL));

  assert_any_fault_R3: assert property (@(posedge clk) disable iff (rst)
    !past_rst |-> (status[ST_ANY] == $past(|flags)));

  assert_fuse_fail_R4: assert property (@(posedge clk) disable iff (rst)
    !past_rst |-> (status[ST_FUSE] == $past(flags[CH_FH] | flags[CH_FL])));

  assert_tick_only_R8: assert property (@(posedge clk) disable iff (rst)
    (!past_rst && flags != $past(flags)) |-> $past(tick));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_adopt
    assert_adopt_input_R5: assert property (@(posedge clk) disable iff (rst)
      (!past_rst && flags[c] != $past(flags[c])) |-> (flags[c] == $past(synced[c])));
  end

endmodule

bind fault_status_agg fault_status_agg_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .tick   (tick),
  .flags  (flt_q),
  .synced (sync_q),
  .status (status_o)
);

// File: tb/fault_status_agg_bench.sv
module fault_status_agg_bench;

  localparam int OV_N  = 8;
  localparam int UVS_N = 3;
  localparam int UVC_N = 12;
  localparam int BOS_N = 3;
  localparam int BOC_N = 10;
  localparam int OC_N  = 6;
  localparam int STS_N = 5;
  localparam int STC_N = 9;
  localparam int INR_N = 14;
  localparam int FU_N  = 7;
  localparam int HOLD  = 20;

  // raw vector: [7]fuse_lo [6]fuse_hi [5]inrush_done [4]seat_ok [3]oc [2]bo [1]uv [0]ov
  // entry = {raw, expected status}
  localparam int NV = 9;
  localparam logic [15:0] VEC [NV] = '{
    16'h30_00, 16'h31_81, 16'h38_C0, 16'h70_90, 16'hB0_90,
    16'h20_84, 16'h10_88, 16'h36_A2, 16'h30_00
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic [7:0] raw = 8'h30;
  logic [7:0] status;
  logic ov, uv, bo, oc, seat_bad, inr_pend, fh, fl;
  int   total = 0;
  int   bad   = 0;
  logic done  = 1'b0;

  always #5 clk = ~clk;

  fault_status_agg #(
    .SYNC_STAGES(2), .OV_TICKS(OV_N), .UV_SET_TICKS(UVS_N), .UV_CLR_TICKS(UVC_N),
    .BO_SET_TICKS(BOS_N), .BO_CLR_TICKS(BOC_N), .OC_TICKS(OC_N),
    .SEAT_SET_TICKS(STS_N), .SEAT_CLR_TICKS(STC_N), .INR_TICKS(INR_N), .FUSE_TICKS(FU_N)
  ) u_fault_status_agg (
    .clk(clk), .rst(rst), .tick(tick),
    .ov_raw(raw[0]), .uv_raw(raw[1]), .brownout_raw(raw[2]), .oc_raw(raw[3]),
    .seat_ok_raw(raw[4]), .inrush_done_raw(raw[5]),
    .fuse_hi_open_raw(raw[6]), .fuse_lo_open_raw(raw[7]),
    .status_o(status), .ov_o(ov), .uv_o(uv), .brownout_o(bo), .oc_o(oc),
    .seat_bad_o(seat_bad), .inrush_pend_o(inr_pend),
    .fuse_hi_open_o(fh), .fuse_lo_open_o(fl)
  );

  function automatic logic [7:0] flags_now();
    return {fl, fh, inr_pend, seat_bad, oc, bo, uv, ov};
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    check("R2 reset status", status, 8'h9F);
    check("R2 reset flags", flags_now(), 8'hF3);
    rst = 1'b0;

    // vector walk: each entry holds long enough for every filter to settle
    for (int i = 0; i < NV; i++) begin
      raw = VEC[i][15:8];
      step(HOLD);
      check("R1 R3 R4 R9 vector status", status, VEC[i][7:0]);
    end

    // R5: exact overvoltage set and clear edges, status one clock later
    raw[0] = 1'b1;
    step(OV_N + 1);
    check("R5 ov before set edge", {7'd0, ov}, 8'd0);
    step(1);
    check("R5 ov at set edge", {7'd0, ov}, 8'd1);
    check("R1 status lags flag", status, 8'h00);
    step(1);
    check("R1 status after lag", status, 8'h81);
    raw[0] = 1'b0;
    step(OV_N + 1);
    check("R5 ov before clear edge", {7'd0, ov}, 8'd1);
    step(1);
    check("R5 ov at clear edge", {7'd0, ov}, 8'd0);

    // R7: undervoltage sets fast, clears slow
    raw[1] = 1'b1;
    step(UVS_N + 1);
    check("R7 uv before set edge", {7'd0, uv}, 8'd0);
    step(1);
    check("R7 uv at set edge", {7'd0, uv}, 8'd1);
    raw[1] = 1'b0;
    step(UVC_N + 1);
    check("R7 uv before clear edge", {7'd0, uv}, 8'd1);
    step(1);
    check("R7 uv at clear edge", {7'd0, uv}, 8'd0);

    // R6: pulses one tick short, with one-cycle gaps, never trip the fuse flag
    raw[6] = 1'b1; step(FU_N - 1);
    raw[6] = 1'b0; step(1);
    raw[6] = 1'b1; step(FU_N - 1);
    raw[6] = 1'b0; step(HOLD);
    check("R6 short pulse train ignored", {7'd0, fh}, 8'd0);
    check("R6 status unchanged", status, 8'h00);
    raw[6] = 1'b1; step(FU_N);
    raw[6] = 1'b0; step(2);
    check("R6 full-length pulse trips", {7'd0, fh}, 8'd1);
    step(HOLD);
    check("R6 fuse flag clears again", {7'd0, fh}, 8'd0);

    // R8: no progress while tick is low
    tick = 1'b0;
    raw[3] = 1'b1;
    step(40);
    check("R8 oc held without tick", {7'd0, oc}, 8'd0);
    tick = 1'b1;
    step(OC_N + 3);
    check("R8 oc moves once ticks resume", {7'd0, oc}, 8'd1);

    // R10: warnings touch only their own bits and any-fault
    raw[2] = 1'b1;
    step(HOLD);
    check("R10 warnings flags", flags_now(), 8'h0C);
    check("R10 warnings status", status, 8'hE0);

    // R2: reset in mid-run
    raw = 8'h30;
    rst = 1'b1;
    step(2);
    check("R2 mid-run reset status", status, 8'h9F);
    check("R2 mid-run reset flags", flags_now(), 8'hF3);
    rst = 1'b0;
    step(HOLD);
    check("R2 recovery to normal", status, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule